// File: doc/BRIEF.md
# Packet-Mode I2C Transfer Sequencer

This block sits between a 32-bit transmit FIFO and a byte-level I2C engine. Software describes each bus transfer as a small packet placed in the transmit FIFO: three header words, then, for writes, payload words. The sequencer reads the header words and works out the protocol, the byte count, the target address, the direction and the chaining flags. It then hands the engine one command at a time: start or repeated start, the address byte, the data bytes and a final stop.

Bytes read from the bus are gathered into 32-bit words and pushed to a receive FIFO. Completion and no-acknowledge events are reported on status outputs. A register read is two chained packets. The first is a one-byte write of the register index with the repeated-start flag set. The second is the read, which then begins with a repeated start rather than a fresh start.

Top module: `i2c_pkt_sequencer`

## Requirements
- R1: After reset no command is offered (cmd_valid low), no FIFO word is popped, and rx_push, pkt_done, all_done, pkt_irq and nack_flag are all low.
- R2: A packet opens with three header words. In word 0, bit 4 set selects I2C. In word 1, bits [4:0] hold the byte count minus one. In word 2, bits [7:1] hold the 7-bit address, bit 19 selects a read, bit 16 requests a repeated start at the end, bit 17 enables the completion interrupt and bit 15 marks a continued transfer. An I2C packet issues a start, then a write of the address byte {addr, read}.
- R3: Write payload bytes are taken four per word, least significant byte first, each sent as a WRITE command. Only byte-count bytes are sent, and the unused upper bytes of a partial last word are ignored.
- R4: A read issues byte-count READ commands, with cmd_last high only on the final one. Returned bytes are packed least significant byte first. Each full word is pushed, and a partial last word is pushed with its upper bytes zero.
- R5: A packet ends with STOP unless bit 16 or bit 15 is set. After a bit-16 packet, the next packet begins with RSTART. After a bit-15 packet, the next packet sends its data directly, with no start and no address byte.
- R6: A no-acknowledge on the address or on any write byte sets nack_flag, which stays set until reset. No further data byte is sent, the remaining payload words of that packet are popped and dropped, and a STOP follows.
- R7: pkt_done pulses for one cycle at the end of every packet. pkt_irq pulses in the same cycle only when header bit 17 was set.
- R8: all_done pulses together with pkt_done only when the packet ended with a STOP and the transmit FIFO was empty at that moment.
- R9: A packet whose word 0 has bit 4 clear issues no command. Its header words and write payload words are popped, and pkt_done pulses.
- R10: Command codes are START=0, RSTART=1, WRITE=2, READ=3 and STOP=4. A command is held unchanged while cmd_ready is low. Only one command is outstanding, and the next one is offered only after resp_valid.
- R11: The full 32-byte packet (count field 31) and the 1-byte packet (count field 0) are both handled completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 32 | Word at the head of the transmit FIFO |
| tx_pop | output | 1 | Removes the head word |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte for WRITE commands |
| cmd_last | output | 1 | Final READ of the packet (master does not acknowledge) |
| resp_valid | input | 1 | Engine finished the outstanding command |
| resp_byte | input | 8 | Byte returned by a READ |
| resp_nack | input | 1 | Target did not acknowledge a WRITE |
| rx_push | output | 1 | Pushes rx_data to the receive FIFO |
| rx_data | output | 32 | Packed received word |
| pkt_done | output | 1 | Packet finished (pulse) |
| all_done | output | 1 | Finished with STOP and nothing queued (pulse) |
| pkt_irq | output | 1 | Completion interrupt of a bit-17 packet (pulse) |
| nack_flag | output | 1 | Sticky no-acknowledge status |

## Verification
Two events can fall on the same engine response: a no-acknowledge on a write byte, and the end of that packet's byte count. The bench provokes this by refusing acknowledgement on the last byte of a one-word packet, with a second packet already queued behind it. The response must take the no-acknowledge path: the flag is set and a STOP is issued. The drop logic must not swallow the next packet's words, so the queued packet has to run in full afterwards. In the same way, the completion of the last read word and the partial-word push meet on one response; this is judged through the zero upper bytes of the final received word.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;

    localparam int PROT_I2C_BIT = 4;
    localparam int READ_BIT     = 19;
    localparam int IRQ_BIT      = 17;
    localparam int RSTART_BIT   = 16;
    localparam int CONT_BIT     = 15;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR1, S_HDR2, S_BEGIN, S_ADDR, S_WLOAD, S_WBYTE,
        S_RBYTE, S_END, S_DRAIN, S_STOP, S_DONE
    } st_e;

    typedef enum logic [1:0] {
        HOLD_NONE, HOLD_RS, HOLD_CONT
    } hold_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic       rstart;
        logic       ie;
        logic       cont;
    } hdr_t;

endpackage

// File: rtl/i2cps_hdr_decode.sv
module i2cps_hdr_decode
    import i2cps_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    output hdr_t              fields,
    output logic              is_i2c
);
    logic unused_bits;

    always_comb begin
        fields.addr   = word[7:1];
        fields.rd     = word[READ_BIT];
        fields.rstart = word[RSTART_BIT];
        fields.ie     = word[IRQ_BIT];
        fields.cont   = word[CONT_BIT];
        is_i2c        = word[PROT_I2C_BIT];
    end

    assign unused_bits = ^{word[WORD_W-1:20], word[18], word[14:8], word[0]};
endmodule

// File: rtl/i2cps_lane_pick.sv
module i2cps_lane_pick #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        lane
);
    localparam int LANES = WORD_W / 8;

    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (idx == IDX_W'(i)) lane = word[i*8 +: 8];
        end
    end
endmodule

// File: rtl/i2cps_lane_merge.sv
module i2cps_lane_merge #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        lane,
    output logic [WORD_W-1:0] merged
);
    localparam int LANES = WORD_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = (idx == IDX_W'(g)) ? lane : word[g*8 +: 8];
    end
endmodule

// File: rtl/i2c_pkt_sequencer.sv
module i2c_pkt_sequencer
    import i2cps_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_valid,
    input  logic [31:0] tx_data,
    output logic        tx_pop,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [2:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    output logic        cmd_last,
    input  logic        resp_valid,
    input  logic [7:0]  resp_byte,
    input  logic        resp_nack,
    output logic        rx_push,
    output logic [31:0] rx_data,
    output logic        pkt_done,
    output logic        all_done,
    output logic        pkt_irq,
    output logic        nack_flag
);
    localparam int BPW    = WORD_W / 8;
    localparam int IDX_W  = $clog2(BPW);
    localparam int CNT_W  = $clog2(MAX_BYTES);
    localparam int LEFT_W = CNT_W + 1;
    localparam int WCNT_W = CNT_W - IDX_W + 1;

    typedef struct packed {
        st_e                st;
        logic               busy;
        logic               is_i2c;
        hdr_t               hdr;
        hold_e              held;
        logic               stop_sent;
        logic [LEFT_W-1:0]  left;
        logic [WCNT_W-1:0]  words;
        logic [IDX_W-1:0]   idx;
        logic [WORD_W-1:0]  wbuf;
        logic [WORD_W-1:0]  rbuf;
        logic               rx_push;
        logic [WORD_W-1:0]  rx_data;
        logic               done;
        logic               all;
        logic               irq;
        logic               nack;
    } state_t;

    state_t q, d;

    hdr_t              hdr_w;
    logic              is_i2c_w;
    logic [7:0]        wr_byte;
    logic [WORD_W-1:0] rd_merged;
    logic              rsp;
    logic              last_byte;

    i2cps_hdr_decode #(.WORD_W(WORD_W)) u_dec (
        .word(tx_data), .fields(hdr_w), .is_i2c(is_i2c_w)
    );

    i2cps_lane_pick #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_pick (
        .word(q.wbuf), .idx(q.idx), .lane(wr_byte)
    );

    i2cps_lane_merge #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_merge (
        .word(q.rbuf), .idx(q.idx), .lane(resp_byte), .merged(rd_merged)
    );

    assign rsp       = q.busy & resp_valid;
    assign last_byte = (q.left == LEFT_W'(1));

    always_comb begin
        d         = q;
        d.rx_push = 1'b0;
        d.done    = 1'b0;
        d.all     = 1'b0;
        d.irq     = 1'b0;
        tx_pop    = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = OP_STOP;
        cmd_byte  = '0;
        cmd_last  = 1'b0;

        unique case (q.st)
            S_IDLE: if (tx_valid) begin
                tx_pop   = 1'b1;
                d.is_i2c = is_i2c_w;
                d.st     = S_HDR1;
            end
            S_HDR1: if (tx_valid) begin
                tx_pop  = 1'b1;
                d.left  = LEFT_W'(tx_data[CNT_W-1:0]) + LEFT_W'(1);
                d.words = WCNT_W'(tx_data[CNT_W-1:IDX_W]) + WCNT_W'(1);
                d.st    = S_HDR2;
            end
            S_HDR2: if (tx_valid) begin
                tx_pop      = 1'b1;
                d.hdr       = hdr_w;
                d.stop_sent = 1'b0;
                d.idx       = '0;
                d.rbuf      = '0;
                if (hdr_w.rd) d.words = '0;
                if (!q.is_i2c) begin
                    d.st = S_DRAIN;
                end else if (q.held == HOLD_CONT) begin
                    d.held = HOLD_NONE;
                    d.st   = hdr_w.rd ? S_RBYTE : S_WLOAD;
                end else begin
                    d.st = S_BEGIN;
                end
            end
            S_BEGIN: begin
                cmd_valid = !q.busy;
                cmd_op    = (q.held == HOLD_RS) ? OP_RSTART : OP_START;
                if (rsp) begin
                    d.held = HOLD_NONE;
                    d.st   = S_ADDR;
                end
            end
            S_ADDR: begin
                cmd_valid = !q.busy;
                cmd_op    = OP_WRITE;
                cmd_byte  = {q.hdr.addr, q.hdr.rd};
                if (rsp) begin
                    if (resp_nack) begin
                        d.nack = 1'b1;
                        d.st   = S_DRAIN;
                    end else begin
                        d.st = q.hdr.rd ? S_RBYTE : S_WLOAD;
                    end
                end
            end
            S_WLOAD: if (tx_valid) begin
                tx_pop  = 1'b1;
                d.wbuf  = tx_data;
                d.idx   = '0;
                d.words = q.words - WCNT_W'(1);
                d.st    = S_WBYTE;
            end
            S_WBYTE: begin
                cmd_valid = !q.busy;
                cmd_op    = OP_WRITE;
                cmd_byte  = wr_byte;
                if (rsp) begin
                    if (resp_nack) begin
                        d.nack = 1'b1;
                        d.st   = S_DRAIN;
                    end else begin
                        d.left = q.left - LEFT_W'(1);
                        d.idx  = q.idx + IDX_W'(1);
                        if (last_byte)                         d.st = S_END;
                        else if (q.idx == IDX_W'(BPW - 1))     d.st = S_WLOAD;
                    end
                end
            end
            S_RBYTE: begin
                cmd_valid = !q.busy;
                cmd_op    = OP_READ;
                cmd_last  = last_byte;
                if (rsp) begin
                    d.left = q.left - LEFT_W'(1);
                    if (last_byte || q.idx == IDX_W'(BPW - 1)) begin
                        d.rx_push = 1'b1;
                        d.rx_data = rd_merged;
                        d.rbuf    = '0;
                        d.idx     = '0;
                    end else begin
                        d.rbuf = rd_merged;
                        d.idx  = q.idx + IDX_W'(1);
                    end
                    if (last_byte) d.st = S_END;
                end
            end
            S_END: begin
                if (q.hdr.rstart) begin
                    d.held = HOLD_RS;
                    d.st   = S_DONE;
                end else if (q.hdr.cont) begin
                    d.held = HOLD_CONT;
                    d.st   = S_DONE;
                end else begin
                    d.st = S_STOP;
                end
            end
            S_DRAIN: begin
                if (q.words == '0) begin
                    d.st = q.is_i2c ? S_STOP : S_DONE;
                end else if (tx_valid) begin
                    tx_pop  = 1'b1;
                    d.words = q.words - WCNT_W'(1);
                end
            end
            S_STOP: begin
                cmd_valid = !q.busy;
                cmd_op    = OP_STOP;
                if (rsp) begin
                    d.stop_sent = 1'b1;
                    d.held      = HOLD_NONE;
                    d.st        = S_DONE;
                end
            end
            S_DONE: begin
                d.done = 1'b1;
                d.irq  = q.hdr.ie;
                d.all  = q.stop_sent & !tx_valid;
                d.st   = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        d.busy = q.busy ? !resp_valid : (cmd_valid & cmd_ready);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_push   = q.rx_push;
    assign rx_data   = q.rx_data;
    assign pkt_done  = q.done;
    assign all_done  = q.all;
    assign pkt_irq   = q.irq;
    assign nack_flag = q.nack;
endmodule

// File: rtl/i2cps_checks.sv
module i2cps_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_pop,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       cmd_last,
    input logic       pkt_done,
    input logic       all_done,
    input logic       pkt_irq,
    input logic       nack_flag
);
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_last));

    p_nack_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nack_flag |=> nack_flag);

    p_all_with_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> pkt_done);

    p_irq_with_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_irq |-> pkt_done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);
endmodule

bind i2c_pkt_sequencer i2cps_checks u_checks (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_last(cmd_last), .pkt_done(pkt_done),
    .all_done(all_done), .pkt_irq(pkt_irq), .nack_flag(nack_flag)
);

// File: tb/i2c_pkt_sequencer_test.sv
module i2c_pkt_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int OST = 0, ORS = 1, OWR = 2, ORD = 3, OSP = 4;

    logic clk = 0, rst_n = 0;
    logic        tx_valid, tx_pop;
    logic [31:0] tx_data;
    logic        cmd_valid, cmd_ready = 0, cmd_last;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        resp_valid = 0, resp_nack = 0;
    logic [7:0]  resp_byte = 0;
    logic        rx_push, pkt_done, all_done, pkt_irq, nack_flag;
    logic [31:0] rx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_pkt_sequencer uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_last(cmd_last), .resp_valid(resp_valid), .resp_byte(resp_byte),
        .resp_nack(resp_nack), .rx_push(rx_push), .rx_data(rx_data), .pkt_done(pkt_done),
        .all_done(all_done), .pkt_irq(pkt_irq), .nack_flag(nack_flag)
    );

    // transmit FIFO model
    logic [31:0] fifo [0:255];
    int head = 0, tail = 0;
    assign tx_valid = (head != tail);
    assign tx_data  = fifo[head[7:0]];
    always @(posedge clk) if (tx_pop) head <= head + 1;

    task automatic push(input logic [31:0] w);
        fifo[tail[7:0]] = w;
        tail = tail + 1;
    endtask

    // counters and logs
    int n_chk = 0, n_err = 0;
    int lg = 0, en = 0, rxn = 0, pkt_cnt = 0, all_cnt = 0, irq_cnt = 0;
    int rd_cnt = 0, nack_at = -1, overlap = 0, eng = 0, ecnt = 0;
    logic [11:0] log_e [0:99];
    logic [11:0] exp_e [0:99];
    logic [31:0] rx_log [0:15];
    logic        pend_nack = 0;
    logic [2:0]  pend_op = 0;

    // byte engine model, with one stall cycle before accepting
    always @(negedge clk) begin
        resp_valid = 0;
        resp_nack  = 0;
        case (eng)
            0: if (cmd_valid) begin
                log_e[lg] = {cmd_op, cmd_byte, cmd_last};
                pend_nack = (lg == nack_at);
                pend_op   = cmd_op;
                lg = lg + 1;
                eng = 1;
            end
            1: begin
                if (!cmd_valid) overlap = overlap + 1;
                cmd_ready = 1;
                eng = 2;
                ecnt = 2;
            end
            default: begin
                cmd_ready = 0;
                if (cmd_valid) overlap = overlap + 1;
                if (ecnt == 0) begin
                    resp_valid = 1;
                    resp_nack  = pend_nack;
                    if (pend_op == 3'(ORD)) begin
                        resp_byte = 8'hC0 + 8'(rd_cnt);
                        rd_cnt = rd_cnt + 1;
                    end
                    eng = 0;
                end else ecnt = ecnt - 1;
            end
        endcase
    end

    // output monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_push) begin rx_log[rxn[3:0]] = rx_data; rxn = rxn + 1; end
        pkt_cnt = pkt_cnt + int'(pkt_done);
        all_cnt = all_cnt + int'(all_done);
        irq_cnt = irq_cnt + int'(pkt_irq);
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr2(input logic [6:0] a, input bit rd, input bit rs, input bit ie, input bit ct);
        return (32'(rd) << 19) | (32'(ie) << 17) | (32'(rs) << 16) | (32'(ct) << 15) | {24'd0, a, 1'b0};
    endfunction

    task automatic pkt_hdr(input logic [31:0] w0, input int nbytes, input logic [31:0] w2);
        push(w0);
        push(32'(nbytes - 1));
        push(w2);
    endtask

    task automatic ex(input int op, input logic [7:0] b, input bit last);
        exp_e[en] = {3'(op), b, last};
        en = en + 1;
    endtask

    task automatic begin_test();
        lg = 0; en = 0; rxn = 0; pkt_cnt = 0; all_cnt = 0; irq_cnt = 0;
        rd_cnt = 0; nack_at = -1; overlap = 0;
    endtask

    task automatic wait_pkts(input int n, input string req);
        int t = 0;
        while (pkt_cnt < n && t < 20000) begin @(negedge clk); t++; end
        repeat (12) @(negedge clk);
        chk(pkt_cnt == n, req, "packet completions", pkt_cnt, n);
    endtask

    task automatic cmp_log(input string req);
        chk(lg == en, req, "command count", lg, en);
        for (int i = 0; i < en && i < lg; i++)
            chk(log_e[i] == exp_e[i], req, $sformatf("command %0d {op,byte,last}", i), log_e[i], exp_e[i]);
        chk(overlap == 0, "R10", "command offered while one outstanding or withdrawn", overlap, 0);
    endtask

    task automatic t_reset();
        chk(cmd_valid == 0 && tx_pop == 0, "R1", "cmd_valid/tx_pop after reset", {cmd_valid, tx_pop}, 0);
        chk({rx_push, pkt_done, all_done, pkt_irq, nack_flag} == 0, "R1", "status after reset",
            {rx_push, pkt_done, all_done, pkt_irq, nack_flag}, 0);
    endtask

    task automatic t_write5();
        begin_test();
        pkt_hdr(32'h10, 5, hdr2(7'h3A, 0, 0, 0, 0));
        push(32'h14131211);
        push(32'hEEEEEE15);
        ex(OST, 0, 0); ex(OWR, 8'h74, 0);
        for (int i = 0; i < 5; i++) ex(OWR, 8'h11 + 8'(i), 0);
        ex(OSP, 0, 0);
        wait_pkts(1, "R7");
        cmp_log("R3");
        chk(all_cnt == 1, "R8", "all_done after stop with empty FIFO", all_cnt, 1);
        chk(irq_cnt == 0, "R7", "no irq without bit 17", irq_cnt, 0);
        chk(!tx_valid, "R3", "partial word consumed", tx_valid, 0);
    endtask

    task automatic t_regread();
        begin_test();
        pkt_hdr(32'h10, 1, hdr2(7'h3A, 0, 1, 0, 0));
        push(32'h0000002C);
        pkt_hdr(32'h10, 6, hdr2(7'h3A, 1, 0, 1, 0));
        ex(OST, 0, 0); ex(OWR, 8'h74, 0); ex(OWR, 8'h2C, 0);
        ex(ORS, 0, 0); ex(OWR, 8'h75, 0);
        for (int i = 0; i < 6; i++) ex(ORD, 0, i == 5);
        ex(OSP, 0, 0);
        wait_pkts(2, "R7");
        cmp_log("R5");
        chk(rxn == 2, "R4", "received word count", rxn, 2);
        chk(rx_log[0] == 32'hC3C2C1C0, "R4", "first received word", rx_log[0], 32'hC3C2C1C0);
        chk(rx_log[1] == 32'h0000C5C4, "R4", "partial received word", rx_log[1], 32'h0000C5C4);
        chk(irq_cnt == 1, "R7", "irq count", irq_cnt, 1);
        chk(all_cnt == 1, "R8", "all_done only after stop", all_cnt, 1);
    endtask

    task automatic t_back2back();
        begin_test();
        pkt_hdr(32'h10, 1, hdr2(7'h11, 0, 0, 0, 0)); push(32'h000000A1);
        pkt_hdr(32'h10, 1, hdr2(7'h12, 0, 0, 0, 0)); push(32'h000000A2);
        ex(OST, 0, 0); ex(OWR, 8'h22, 0); ex(OWR, 8'hA1, 0); ex(OSP, 0, 0);
        ex(OST, 0, 0); ex(OWR, 8'h24, 0); ex(OWR, 8'hA2, 0); ex(OSP, 0, 0);
        wait_pkts(2, "R7");
        cmp_log("R2");
        chk(all_cnt == 1, "R8", "all_done suppressed while FIFO not empty", all_cnt, 1);
    endtask

    task automatic t_cont();
        begin_test();
        pkt_hdr(32'h10, 2, hdr2(7'h3A, 0, 0, 0, 1)); push(32'h00005150);
        pkt_hdr(32'h10, 3, hdr2(7'h3A, 0, 0, 0, 0)); push(32'h00545352);
        ex(OST, 0, 0); ex(OWR, 8'h74, 0);
        for (int i = 0; i < 5; i++) ex(OWR, 8'h50 + 8'(i), 0);
        ex(OSP, 0, 0);
        wait_pkts(2, "R5");
        cmp_log("R5");
        chk(all_cnt == 1, "R8", "all_done after continued pair", all_cnt, 1);
    endtask

    task automatic t_foreign();
        begin_test();
        pkt_hdr(32'h00, 6, hdr2(7'h3A, 0, 0, 0, 0));
        push(32'h04030201); push(32'h00000605);
        wait_pkts(1, "R9");
        cmp_log("R9");
        chk(!tx_valid, "R9", "payload words popped", tx_valid, 0);
        chk(all_cnt == 0, "R9", "no all_done without stop", all_cnt, 0);
    endtask

    task automatic t_max();
        begin_test();
        pkt_hdr(32'h10, 32, hdr2(7'h21, 0, 0, 0, 0));
        for (int w = 0; w < 8; w++)
            push({8'(4*w + 4), 8'(4*w + 3), 8'(4*w + 2), 8'(4*w + 1)});
        pkt_hdr(32'h10, 1, hdr2(7'h21, 1, 0, 0, 0));
        ex(OST, 0, 0); ex(OWR, 8'h42, 0);
        for (int i = 0; i < 32; i++) ex(OWR, 8'(i + 1), 0);
        ex(OSP, 0, 0);
        ex(OST, 0, 0); ex(OWR, 8'h43, 0); ex(ORD, 0, 1); ex(OSP, 0, 0);
        wait_pkts(2, "R11");
        cmp_log("R11");
        chk(rxn == 1 && rx_log[0] == 32'h000000C0, "R11", "single-byte read word", rx_log[0], 32'hC0);
    endtask

    task automatic t_nack_addr();
        begin_test();
        nack_at = 1;
        pkt_hdr(32'h10, 9, hdr2(7'h50, 0, 0, 0, 0));
        push(32'h11111111); push(32'h22222222); push(32'h33333333);
        ex(OST, 0, 0); ex(OWR, 8'hA0, 0); ex(OSP, 0, 0);
        wait_pkts(1, "R6");
        cmp_log("R6");
        chk(nack_flag == 1, "R6", "nack flag set", nack_flag, 1);
        chk(!tx_valid, "R6", "remaining payload dropped", tx_valid, 0);
    endtask

    task automatic t_nack_last();
        begin_test();
        nack_at = 5;
        pkt_hdr(32'h10, 4, hdr2(7'h3A, 0, 0, 0, 0)); push(32'h64636261);
        pkt_hdr(32'h10, 1, hdr2(7'h3B, 0, 0, 0, 0)); push(32'h00000077);
        ex(OST, 0, 0); ex(OWR, 8'h74, 0);
        for (int i = 0; i < 4; i++) ex(OWR, 8'h61 + 8'(i), 0);
        ex(OSP, 0, 0);
        ex(OST, 0, 0); ex(OWR, 8'h76, 0); ex(OWR, 8'h77, 0); ex(OSP, 0, 0);
        wait_pkts(2, "R6");
        cmp_log("R6");
        chk(nack_flag == 1, "R6", "flag still set after later packet", nack_flag, 1);
        chk(all_cnt == 1, "R8", "all_done at end of queue", all_cnt, 1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_write5();
        t_regread();
        t_back2back();
        t_cont();
        t_foreign();
        t_max();
        t_nack_addr();
        t_nack_last();
        summary();
    end
endmodule